// File: doc/BRIEF.md
# External Bus Wait-State Controller

This block times a single external memory bus cycle on behalf of a bus master. When a start request arrives while the block is idle and the master qualifier is high, it opens a cycle. It holds the cycle open until two conditions are true. First, a programmed minimum number of wait clocks must have run. Second, the external active-low transfer acknowledge must have been seen asserted. The acknowledge can stretch the cycle without any limit. When both conditions are met, the block emits a one-clock done strobe and returns to idle.

The minimum wait count arrives on a plain input port and is captured when the cycle starts. A count of zero gives a fixed single-clock cycle in which the acknowledge plays no part. The acknowledge is only sampled when the block owns the bus and a cycle is starting or running. At any other time it is ignored.

Top module: `waitStateCtl`

Clocks are numbered from the acceptance edge, which is the rising edge that samples the start request. Clock 1 is the period that follows that edge, and clock j follows the (j-1)-th edge after it. Acknowledge delay D means that ackN is first sampled low D edges after the acceptance edge. D = 0 is the acceptance edge itself.

## Requirements
- R1: While reset is held and in the first clock after it, busy = 0 and cycleDone = 0.
- R2: A start request sampled while idle with isMaster = 1 makes busy = 1 in clock 1.
- R3: A start request sampled while isMaster = 0 is ignored: busy stays 0.
- R4: With a captured count W ≥ 1, cycleDone is high exactly in clock max(W, D+1).
- R5: If the acknowledge is sampled low before the minimum expires, the cycle ends exactly in clock W.
- R6: With W = 0, cycleDone is high in clock 1, even if the acknowledge is never asserted.
- R7: With W ≥ 1 and the acknowledge held high, the cycle never completes. Busy stays 1 for as long as the acknowledge stays high, which is checked over 300 clocks.
- R8: An acknowledge sampled low while isMaster = 0 during a cycle does not count toward completion.
- R9: An acknowledge held low while the block is idle does not count toward the next cycle.
- R10: cycleDone lasts one clock, and busy is 0 in the clock after it. A start request held high through the cycle is not taken again until that idle clock has ended, so busy is 1 again in the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rstN | input | 1 | Active-low synchronous reset |
| cycleStart | input | 1 | Request to open an external bus cycle |
| isMaster | input | 1 | High while this block owns the external bus |
| waitCount | input | WW | Programmed minimum wait clocks, captured at the start of a cycle |
| ackN | input | 1 | Active-low transfer acknowledge |
| cycleDone | output | 1 | One-clock strobe marking the final clock of the cycle |
| busy | output | 1 | High while a cycle is in progress |

## Verification
The bench sweeps every count from 0 to 7 against every acknowledge delay from 0 to 10. It compares the clock in which done appears with max(W, D+1), or with clock 1 when W is 0. A design that ended on the first condition met would finish too early wherever the two delays differ. A design that let the acknowledge extend a zero-count cycle would hang. The bench also checks for an acknowledge that is stale from the idle period, or that arrives while another master owns the bus. A design that latched either of these would finish short. It then runs a 300-clock stall and a start request held high through a whole cycle. These catch a counter that wraps or self-completes, and a controller that re-enters a cycle without its idle clock.

// File: rtl/waitStateCtl_pkg.sv
package waitStateCtl_pkg;
  // Strobes from control to datapath
  typedef struct packed {
    logic load;      // capture count, restart clock counter
    logic step;      // advance clock counter
    logic sampleAck; // acknowledge may be recorded this edge
  } wsStrobe_t;
endpackage

// File: rtl/waitStateCtl_dp.sv
module waitStateCtl_dp
  import waitStateCtl_pkg::*;
#(
  parameter int WW = 3
) (
  input  logic          clk,
  input  logic          rstN,
  input  wsStrobe_t     strobe,
  input  logic [WW-1:0] waitCount,
  input  logic          ackN,
  output logic          minMet,
  output logic          ackOk
);
  localparam logic [WW-1:0] TICK_MAX = {WW{1'b1}};

  logic [WW-1:0] wLat;
  logic [WW-1:0] tick;
  logic          ackSeen;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wLat    <= '0;
      tick    <= '0;
      ackSeen <= 1'b0;
    end else if (strobe.load) begin
      wLat    <= waitCount;
      tick    <= WW'(1);
      ackSeen <= strobe.sampleAck & ~ackN;
    end else if (strobe.step) begin
      if (tick != TICK_MAX) tick <= tick + WW'(1);
      ackSeen <= ackSeen | (strobe.sampleAck & ~ackN);
    end
  end

  assign minMet = (tick >= wLat);
  assign ackOk  = (wLat == '0) || ackSeen;
endmodule

// File: rtl/waitStateCtl_ctl.sv
module waitStateCtl_ctl
  import waitStateCtl_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      cycleStart,
  input  logic      isMaster,
  input  logic      minMet,
  input  logic      ackOk,
  output wsStrobe_t strobe,
  output logic      cycleDone,
  output logic      busy
);
  logic busyQ;
  logic finish;

  assign finish = busyQ && minMet && ackOk;

  always_comb begin
    strobe.load      = !busyQ && cycleStart && isMaster;
    strobe.step      = busyQ && !finish;
    strobe.sampleAck = isMaster && (strobe.load || strobe.step);
  end

  always_ff @(posedge clk) begin
    if (!rstN)            busyQ <= 1'b0;
    else if (strobe.load) busyQ <= 1'b1;
    else if (finish)      busyQ <= 1'b0;
  end

  assign cycleDone = finish;
  assign busy      = busyQ;
endmodule

// File: rtl/waitStateCtl.sv
module waitStateCtl
  import waitStateCtl_pkg::*;
#(
  parameter int WW = 3
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          cycleStart,
  input  logic          isMaster,
  input  logic [WW-1:0] waitCount,
  input  logic          ackN,
  output logic          cycleDone,
  output logic          busy
);
  wsStrobe_t strobe;
  logic      minMet;
  logic      ackOk;

  waitStateCtl_ctl i_ctl (
    .clk(clk), .rstN(rstN), .cycleStart(cycleStart), .isMaster(isMaster),
    .minMet(minMet), .ackOk(ackOk), .strobe(strobe),
    .cycleDone(cycleDone), .busy(busy)
  );

  waitStateCtl_dp #(.WW(WW)) i_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .waitCount(waitCount),
    .ackN(ackN), .minMet(minMet), .ackOk(ackOk)
  );
endmodule

// File: rtl/waitStateCtl_chk.sv
module waitStateCtl_chk #(
  parameter int WW = 3
) (
  input logic          clk,
  input logic          rstN,
  input logic          cycleStart,
  input logic          isMaster,
  input logic [WW-1:0] waitCount,
  input logic          ackN,
  input logic          cycleDone,
  input logic          busy
);
  // R2
  start_take_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && cycleStart && isMaster) |=> busy);
  // R3
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && !(cycleStart && isMaster)) |=> !busy);
  // R6
  zero_wait_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && cycleStart && isMaster && waitCount == '0) |=> cycleDone);
  // R7
  stay_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !cycleDone) |=> busy);
  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    cycleDone |=> (!cycleDone && !busy));
  // R10
  done_in_cycle_chk: assert property (@(posedge clk) disable iff (!rstN)
    cycleDone |-> busy);
endmodule

bind waitStateCtl waitStateCtl_chk #(.WW(WW)) i_chk (
  .clk(clk), .rstN(rstN), .cycleStart(cycleStart), .isMaster(isMaster),
  .waitCount(waitCount), .ackN(ackN), .cycleDone(cycleDone), .busy(busy)
);

// File: tb/test_waitStateCtl.sv
module test_waitStateCtl;
  localparam int WW = 3;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          cycleStart = 1'b0;
  logic          isMaster = 1'b0;
  logic [WW-1:0] waitCount = '0;
  logic          ackN = 1'b1;
  logic          cycleDone;
  logic          busy;

  int nChecks = 0;
  int nFails  = 0;
  int cycles  = 0;

  always #4 clk = ~clk;

  waitStateCtl #(.WW(WW)) i_waitStateCtl (
    .clk(clk), .rstN(rstN), .cycleStart(cycleStart), .isMaster(isMaster),
    .waitCount(waitCount), .ackN(ackN), .cycleDone(cycleDone), .busy(busy)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  endtask

  // open a cycle with count w, ack low from edge d on; return the done clock
  task automatic runCycle(input int w, input int d, output int doneAt);
    @(negedge clk);
    waitCount = WW'(w); cycleStart = 1'b1; isMaster = 1'b1;
    ackN = (d == 0) ? 1'b0 : 1'b1;
    @(posedge clk);
    doneAt = 0;
    for (int j = 1; j <= 60 && doneAt == 0; j++) begin
      @(negedge clk);
      cycleStart = 1'b0;
      if (cycleDone) doneAt = j;
      ackN = (j >= d) ? 1'b0 : 1'b1;
    end
    ackN = 1'b1;
    @(negedge clk);
    check(!busy && !cycleDone, "R10 idle after done", int'(busy), 0);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        nChecks++; nFails++;
        $display("FAIL watchdog: actual %0d expected %0d", cycles, 150000);
        summary();
      end
    end
  end

  initial begin
    int got;
    int exp;
    repeat (3) @(negedge clk);
    // R1
    check(!busy && !cycleDone, "R1 reset", int'(busy), 0);
    rstN = 1'b1;
    @(negedge clk);
    check(!busy && !cycleDone, "R1 after reset", int'(busy), 0);

    // R3: start without mastership
    cycleStart = 1'b1; isMaster = 1'b0;
    repeat (3) @(negedge clk);
    check(!busy, "R3 start ignored", int'(busy), 0);
    cycleStart = 1'b0;

    // R4 R5 R6 sweep
    for (int w = 0; w <= 7; w++) begin
      for (int d = 0; d <= 10; d++) begin
        runCycle(w, d, got);
        exp = (w == 0) ? 1 : ((w > d + 1) ? w : d + 1);
        if (w == 0)          check(got == exp, "R6 zero count", got, exp);
        else if (d + 1 < w)  check(got == exp, "R5 early ack", got, exp);
        else                 check(got == exp, "R4 cycle length", got, exp);
      end
    end

    // R2
    @(negedge clk);
    waitCount = WW'(2); cycleStart = 1'b1; isMaster = 1'b1; ackN = 1'b1;
    @(negedge clk);
    cycleStart = 1'b0;
    check(busy, "R2 busy in clock 1", int'(busy), 1);
    // R7: no ack for 300 clocks
    got = 0;
    for (int j = 0; j < 300; j++) begin
      @(negedge clk);
      if (!busy || cycleDone) got++;
    end
    check(got == 0, "R7 unbounded stretch", got, 0);
    ackN = 1'b0;
    @(negedge clk);
    check(cycleDone, "R7 done after ack", int'(cycleDone), 1);
    ackN = 1'b1;
    @(negedge clk);

    // R8: ack while not master does not count
    waitCount = WW'(1); cycleStart = 1'b1; isMaster = 1'b1; ackN = 1'b1;
    @(posedge clk);
    @(negedge clk);                  // clock 1
    cycleStart = 1'b0; isMaster = 1'b0; ackN = 1'b0;
    repeat (4) @(negedge clk);       // edges 1..4 ack low, not master
    check(busy && !cycleDone, "R8 foreign ack ignored", int'(cycleDone), 0);
    isMaster = 1'b1; ackN = 1'b1;
    repeat (3) @(negedge clk);
    check(busy && !cycleDone, "R8 still waiting", int'(cycleDone), 0);
    ackN = 1'b0;
    @(negedge clk);
    check(cycleDone, "R8 done after own ack", int'(cycleDone), 1);
    ackN = 1'b1;
    @(negedge clk);

    // R9: stale ack during idle
    ackN = 1'b0; isMaster = 1'b1;
    repeat (3) @(negedge clk);
    check(!busy && !cycleDone, "R9 idle ack no cycle", int'(busy), 0);
    runCycle(1, 3, got);
    check(got == 4, "R9 stale ack ignored", got, 4);

    // R10: start held high throughout
    @(negedge clk);
    waitCount = WW'(3); cycleStart = 1'b1; isMaster = 1'b1; ackN = 1'b0;
    @(posedge clk);
    got = 0;
    for (int j = 1; j <= 10 && got == 0; j++) begin
      @(negedge clk);
      if (cycleDone) got = j;
    end
    check(got == 3, "R10 length with start held", got, 3);
    @(negedge clk);
    check(!busy && !cycleDone, "R10 idle clock", int'(busy), 0);
    @(negedge clk);
    check(busy, "R10 restart after idle", int'(busy), 1);
    cycleStart = 1'b0; ackN = 1'b1;
    repeat (4) @(negedge clk);
    ackN = 1'b0;
    repeat (2) @(negedge clk);
    ackN = 1'b1;
    @(negedge clk);

    summary();
  end
endmodule